// File: doc/BRIEF.md
# Programmable Waveform Sequencer

This block is a small microcoded engine that drives three bus control lines and two strobes from a register table of state descriptors. The table holds several selectable waveforms. Each waveform has seven active states, numbered 0 to 6. Every state is described by four bytes: a length/branch byte, an opcode byte, an output byte and a logic byte. A start strobe latches the selected waveform and enters state 0. The engine then walks the states until it reaches state 7, which is the idle state, and pulses a done flag when it arrives there.

A state is either a timed state or a decision state. A timed state holds its outputs for a programmed number of cycles and then moves on to the next state. A decision state takes one cycle. In that cycle it combines two selected flag inputs with a programmable logic function and branches to one of two targets. The available inputs are a ready line, a terminal-count flag and a FIFO-full flag. An abort input returns the engine to idle at once. A plain byte-write port loads the table and the idle control value. Reset loads a default table: waveform 0 is a FIFO/ready polling loop and the other waveforms are simple seven-cycle sweeps.

Top module: `wseq_top`

## Requirements
- R1: After reset the engine is idle: ctl_o = 3'b101, data_o = 0, next_o = 0, done_o = 0.
- R2: A start pulse while idle latches desc_sel and enters state 0 of that waveform on the next clock edge. The default waveforms 1 to 3 output ctl_o = 3'b101 for seven cycles (states 0 to 6, one cycle each) and then go idle.
- R3: A timed state (opcode bit0 = 0) holds for N cycles, where N is its length byte, and a length of 0 means 256 cycles. It then moves to the next state; after state 6 it goes to idle.
- R4: A decision state (opcode bit0 = 1) lasts one cycle. The logic byte selects the function in bits[7:6] (00 AND, 01 OR, 10 XOR, 11 A AND NOT B), operand A in bits[5:3] and operand B in bits[2:0]. The operand codes are 0 = rdy0, 5 = tc_expired and 6 = fifo_full; every other code reads as 0. If the result is true the engine goes to the state in length bits[5:3], otherwise to the state in length bits[2:0]. A target of 7 means idle.
- R5: In an active state, data_o follows opcode bit1 and next_o follows opcode bit2. In a decision state these strobes are given only when length bit7 (re-execute) is set.
- R6: Default waveform 0: state 0 repeats while fifo_full or rdy0 is high, and otherwise goes to state 1. State 1 gives ctl_o = 3'b100 with data_o = next_o = 1, then goes idle if tc_expired is high and back to state 0 otherwise.
- R7: In an active state ctl_o equals bits[2:0] of the output byte. When idle, ctl_o equals the idle control register, which defaults to 3'b101.
- R8: abort forces the engine to idle on the next edge, with priority over start and over the table.
- R9: done_o is high for exactly one cycle, which is the first idle cycle after a run ends normally or is aborted.
- R10: Writing to the config port with addr bit7 = 1 sets the idle value from wdata[2:0]. With addr bit7 = 0 the write goes to one table byte: the waveform is addr[6:5], the state is addr[4:2] and the byte is addr[1:0] (0 length, 1 opcode, 2 output, 3 logic). Writes to state 7 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, honoured while idle |
| abort | input | 1 | Force the engine to idle |
| desc_sel | input | 2 | Waveform to run, latched at start |
| rdy0 | input | 1 | Ready flag, operand code 0 |
| tc_expired | input | 1 | Terminal-count flag, operand code 5 |
| fifo_full | input | 1 | FIFO-full flag, operand code 6 |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 8 | Config address (see R10) |
| cfg_wdata | input | 8 | Config write data |
| ctl_o | output | 3 | Control outputs, bit0 is CTL0 |
| data_o | output | 1 | Data strobe |
| next_o | output | 1 | Next-data strobe |
| done_o | output | 1 | One-cycle done pulse |

## Verification
The assertions assume that start and abort are synchronous to clk and that table writes only change a state the engine is not executing at that moment. The dwell and strobe checks read the table of the current state, so a write to that state in the middle of a run would break them. The stimulus therefore changes the table and the idle value only while the engine is idle, or after an abort has returned it to idle. The flag inputs are changed freely between edges.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] IDLE_ST = 3'd7;

  // byte slots inside one state descriptor
  localparam int B_LEN = 0;
  localparam int B_OPC = 1;
  localparam int B_OUT = 2;
  localparam int B_LGC = 3;

  typedef enum logic [1:0] {LF_AND = 2'b00, LF_OR = 2'b01, LF_XOR = 2'b10, LF_ANDN = 2'b11} lfn_e;

  // reset contents of the table
  function automatic logic [7:0] default_byte(int d, int s, int b);
    logic [7:0] r;
    if (d == 0 && s == 0)      r = (b == B_LEN) ? 8'h81 : (b == B_OPC) ? 8'h01 : (b == B_OUT) ? 8'h05 : 8'h70;
    else if (d == 0 && s == 1) r = (b == B_LEN) ? 8'hB8 : (b == B_OPC) ? 8'h07 : (b == B_OUT) ? 8'h04 : 8'h2D;
    else if (d == 0)           r = (b == B_LEN) ? 8'h01 : (b == B_OUT) ? 8'h04 : 8'h00;
    else                       r = (b == B_LEN) ? 8'h01 : (b == B_OUT) ? 8'h05 : 8'h00;
    return r;
  endfunction

  // operand code to flag value (R4)
  function automatic logic pick_flag(logic [2:0] code, logic rdy0, logic tc, logic ff);
    case (code)
      3'd0:    return rdy0;
      3'd5:    return tc;
      3'd6:    return ff;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic apply_fn(lfn_e fn, logic a, logic b);
    case (fn)
      LF_AND:  return a & b;
      LF_OR:   return a | b;
      LF_XOR:  return a ^ b;
      default: return a & ~b;
    endcase
  endfunction

  // last count value of a timed state; 0 in the length byte wraps to 255 (256 cycles)
  function automatic logic [7:0] dwell_last_count(logic [7:0] len);
    return len - 8'd1;
  endfunction
endpackage

// File: rtl/wseq_table.sv
module wseq_table
  import wseq_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int NUM_ST   = 7,
  localparam int DESC_W  = $clog2(NUM_DESC),
  localparam int ADDR_W  = DESC_W + 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  input  logic [DESC_W-1:0]   rd_desc,
  input  logic [STATE_W-1:0]  rd_state,
  output logic [3:0][7:0]     rd_word,
  output logic [2:0]          idle_ctl
);
  logic [DESC_W-1:0]  a_desc;
  logic [STATE_W-1:0] a_state;
  logic [1:0]         a_byte;
  logic               a_idle;
  logic               a_state_ok;
  logic [STATE_W-1:0] rd_idx;

  assign a_idle     = addr[ADDR_W-1];
  assign a_desc     = addr[ADDR_W-2 -: DESC_W];
  assign a_state    = addr[4:2];
  assign a_byte     = addr[1:0];
  assign a_state_ok = int'(a_state) < NUM_ST;   // R10 state 7 writes dropped
  assign rd_idx     = (int'(rd_state) < NUM_ST) ? rd_state : '0;

  logic [NUM_DESC-1:0][3:0][7:0] per_desc;

  for (genvar gd = 0; gd < NUM_DESC; gd++) begin : g_desc
    logic [3:0][7:0] rows_q [NUM_ST];
    logic            hit;
    assign hit = we && !a_idle && a_state_ok && (a_desc == DESC_W'(gd));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < NUM_ST; s++)
          for (int b = 0; b < 4; b++)
            rows_q[s][b] <= default_byte(gd, s, b);
      end else if (hit) begin
        rows_q[a_state][a_byte] <= wdata;
      end
    end

    assign per_desc[gd] = rows_q[rd_idx];
  end

  assign rd_word = per_desc[rd_desc];

  // idle control value register (R7, R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                idle_ctl <= 3'b101;
    else if (we && a_idle)     idle_ctl <= wdata[2:0];
  end
endmodule

// File: rtl/wseq_decide.sv
module wseq_decide
  import wseq_pkg::*;
(
  input  logic [7:0] lgc,
  input  logic       rdy0,
  input  logic       tc_expired,
  input  logic       fifo_full,
  output logic       cond
);
  logic op_a, op_b;
  assign op_a = pick_flag(lgc[5:3], rdy0, tc_expired, fifo_full);
  assign op_b = pick_flag(lgc[2:0], rdy0, tc_expired, fifo_full);
  assign cond = apply_fn(lfn_e'(lgc[7:6]), op_a, op_b);   // R4
endmodule

// File: rtl/wseq_core.sv
module wseq_core
  import wseq_pkg::*;
#(
  parameter int NUM_ST = 7,
  parameter int DESC_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                abort,
  input  logic [DESC_W-1:0]   desc_sel,
  input  logic [3:0][7:0]     word,
  input  logic                cond,
  input  logic [2:0]          idle_ctl,
  output logic [STATE_W-1:0]  cur_state,
  output logic [DESC_W-1:0]   cur_desc,
  output logic [2:0]          ctl_o,
  output logic                data_o,
  output logic                next_o,
  output logic                done_o,
  output logic                is_active,
  output logic                is_dec,
  output logic                act_reexec,
  output logic                dwell_last
);
  logic [7:0]         cnt_q;
  logic [STATE_W-1:0] nxt_state;
  logic               act_ok;

  assign is_active  = cur_state != IDLE_ST;
  assign is_dec     = is_active && word[B_OPC][0];
  assign act_reexec = word[B_LEN][7];
  assign dwell_last = cnt_q == dwell_last_count(word[B_LEN]);

  always_comb begin
    if (abort)                                   nxt_state = IDLE_ST;                  // R8
    else if (!is_active)                         nxt_state = start ? '0 : IDLE_ST;     // R2
    else if (is_dec)                             nxt_state = cond ? word[B_LEN][5:3]   // R4
                                                                  : word[B_LEN][2:0];
    else if (!dwell_last)                        nxt_state = cur_state;                // R3
    else if (cur_state == STATE_W'(NUM_ST - 1))  nxt_state = IDLE_ST;
    else                                         nxt_state = cur_state + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state <= IDLE_ST;
      cur_desc  <= '0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
    end else begin
      cur_state <= nxt_state;
      if (!is_active && start) cur_desc <= desc_sel;
      if (!is_active || is_dec || nxt_state != cur_state) cnt_q <= '0;
      else                                                cnt_q <= cnt_q + 8'd1;
      done_o <= is_active && (nxt_state == IDLE_ST);    // R9
    end
  end

  // R5: strobes of a decision state need the re-execute bit
  assign act_ok = !word[B_OPC][0] || act_reexec;
  assign ctl_o  = is_active ? word[B_OUT][2:0] : idle_ctl;   // R7
  assign data_o = is_active && act_ok && word[B_OPC][1];
  assign next_o = is_active && act_ok && word[B_OPC][2];

  logic unused_bits;
  assign unused_bits = ^{word[B_LEN][6], word[B_OPC][7:3], word[B_OUT][7:3], word[B_LGC]};
endmodule

// File: rtl/wseq_top.sv
module wseq_top
  import wseq_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int NUM_ST   = 7,
  localparam int DESC_W  = $clog2(NUM_DESC),
  localparam int ADDR_W  = DESC_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [DESC_W-1:0] desc_sel,
  input  logic              rdy0,
  input  logic              tc_expired,
  input  logic              fifo_full,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [2:0]        ctl_o,
  output logic              data_o,
  output logic              next_o,
  output logic              done_o
);
  logic [STATE_W-1:0] cur_state;
  logic [DESC_W-1:0]  cur_desc;
  logic [3:0][7:0]    word;
  logic [2:0]         idle_ctl;
  logic               cond, is_active, is_dec, act_reexec, dwell_last;

  wseq_table #(.NUM_DESC(NUM_DESC), .NUM_ST(NUM_ST)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rd_desc(cur_desc), .rd_state(cur_state), .rd_word(word), .idle_ctl(idle_ctl)
  );

  wseq_decide u_decide (
    .lgc(word[B_LGC]), .rdy0(rdy0), .tc_expired(tc_expired), .fifo_full(fifo_full), .cond(cond)
  );

  wseq_core #(.NUM_ST(NUM_ST), .DESC_W(DESC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .desc_sel(desc_sel),
    .word(word), .cond(cond), .idle_ctl(idle_ctl),
    .cur_state(cur_state), .cur_desc(cur_desc), .ctl_o(ctl_o), .data_o(data_o),
    .next_o(next_o), .done_o(done_o), .is_active(is_active), .is_dec(is_dec),
    .act_reexec(act_reexec), .dwell_last(dwell_last)
  );
endmodule

// File: rtl/wseq_chk.sv
module wseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       abort,
  input logic [2:0] cur_state,
  input logic       is_active,
  input logic       is_dec,
  input logic       act_reexec,
  input logic       dwell_last,
  input logic [2:0] ctl_o,
  input logic [2:0] idle_ctl,
  input logic       data_o,
  input logic       next_o,
  input logic       done_o
);
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort && is_active |=> !is_active && done_o);                               // R8
  AST_START_ENTERS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !is_active && start && !abort |=> cur_state == 3'd0);                       // R2
  AST_DWELL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    is_active && !is_dec && !dwell_last && !abort |=> $stable(cur_state));      // R3
  AST_DECISION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    is_dec && !act_reexec |-> !data_o && !next_o);                              // R5
  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !is_active |-> !data_o && !next_o && ctl_o == idle_ctl);                    // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);                                                        // R9
  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !is_active && $past(is_active));                                 // R9
endmodule

bind wseq_top wseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .cur_state(cur_state),
  .is_active(is_active), .is_dec(is_dec), .act_reexec(act_reexec), .dwell_last(dwell_last),
  .ctl_o(ctl_o), .idle_ctl(idle_ctl), .data_o(data_o), .next_o(next_o), .done_o(done_o)
);

// File: tb/tb_wseq_top.sv
module tb_wseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, abort = 1'b0;
  logic [1:0] desc_sel = '0;
  logic       rdy0 = 1'b0, tc_expired = 1'b0, fifo_full = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0, cfg_wdata = '0;
  logic [2:0] ctl_o;
  logic       data_o, next_o, done_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  wseq_top dut (.*);

  // {fn[1:0], selA[2:0], selB[2:0], rdy0, tc, ff, expected}
  localparam logic [11:0] VEC [10] = '{
    {2'b00, 3'd0, 3'd5, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'b00, 3'd0, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b01, 3'd6, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'b01, 3'd6, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b10, 3'd5, 3'd6, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b10, 3'd5, 3'd6, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'b11, 3'd0, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b11, 3'd0, 3'd6, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'b01, 3'd3, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'b00, 3'd5, 3'd5, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic go(input logic [1:0] d);
    desc_sel = d; start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic stop();
    abort = 1'b1;
    tick();
    abort = 1'b0;
  endtask

  function automatic logic [7:0] ta(input int d, input int s, input int b);
    return 8'((d << 5) | (s << 2) | b);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    #12 rst_n = 1'b1;
    tick();
    // R1 reset state
    check(ctl_o == 3'b101 && !data_o && !next_o && !done_o, "R1 reset outputs", ctl_o, 5);

    // R4 decision table on waveform 2: s0 decision -> true s1 (ctl 1), false s2 (ctl 2)
    wr(ta(2,0,0), 8'h0A); wr(ta(2,0,1), 8'h01); wr(ta(2,0,2), 8'h00);
    wr(ta(2,1,2), 8'h01); wr(ta(2,2,2), 8'h02);
    foreach (VEC[i]) begin
      wr(ta(2,0,3), {VEC[i][11:10], VEC[i][9:7], VEC[i][6:4]});
      rdy0 = VEC[i][3]; tc_expired = VEC[i][2]; fifo_full = VEC[i][1];
      go(2'd2);
      check(ctl_o == 3'd0, "R4 decision state entered", ctl_o, 0);
      tick();
      check(ctl_o == (VEC[i][0] ? 3'd1 : 3'd2), "R4 branch target", ctl_o, VEC[i][0] ? 1 : 2);
      stop();
      check(done_o == 1'b1, "R8 abort gives done", done_o, 1);
    end
    rdy0 = 0; tc_expired = 0; fifo_full = 0;

    // R5 strobes in a decision state gated by re-execute bit
    wr(ta(2,0,1), 8'h07);
    go(2'd2);
    check(!data_o && !next_o, "R5 decision strobes off without re-execute", data_o, 0);
    stop();
    wr(ta(2,0,0), 8'h8A);
    go(2'd2);
    check(data_o && next_o, "R5 decision strobes with re-execute", data_o, 1);
    stop();

    // R2 and R9: default waveform 1 sweep
    go(2'd1);
    for (int k = 0; k < 7; k++) begin
      check(ctl_o == 3'b101 && !done_o, "R2 default sweep", ctl_o, 5);
      tick();
    end
    check(done_o == 1'b1, "R9 done on normal end", done_o, 1);
    tick();
    check(done_o == 1'b0, "R9 done is one cycle", done_o, 0);

    // R3 dwell on waveform 3
    wr(ta(3,0,0), 8'd3); wr(ta(3,0,2), 8'h01); wr(ta(3,1,2), 8'h02);
    go(2'd3);
    cnt = 0;
    while (ctl_o == 3'd1 && cnt < 300) begin cnt++; tick(); end
    check(cnt == 3, "R3 dwell of 3", cnt, 3);
    check(ctl_o == 3'd2, "R3 next state after dwell", ctl_o, 2);
    stop();
    wr(ta(3,0,0), 8'd0);
    go(2'd3);
    cnt = 0;
    while (ctl_o == 3'd1 && cnt < 300) begin cnt++; tick(); end
    check(cnt == 256, "R3 length 0 dwells 256", cnt, 256);
    stop();

    // R6 default waveform 0
    rdy0 = 1'b1;
    go(2'd0);
    check(ctl_o == 3'b101 && !data_o, "R6 state 0 outputs", ctl_o, 5);
    tick();
    check(ctl_o == 3'b101, "R6 hold while rdy0", ctl_o, 5);
    rdy0 = 1'b0; fifo_full = 1'b1;
    tick();
    check(ctl_o == 3'b101, "R6 hold while fifo_full", ctl_o, 5);
    fifo_full = 1'b0;
    tick();
    check(ctl_o == 3'b100 && data_o && next_o, "R6 state 1 strobes", ctl_o, 4);
    tick();
    check(ctl_o == 3'b101 && !data_o, "R6 back to state 0 without tc", ctl_o, 5);
    tick();
    tc_expired = 1'b1;
    tick();
    check(done_o && !data_o, "R6 tc ends run", done_o, 1);
    tc_expired = 1'b0;

    // R7 and R10 idle value register
    wr(8'h80, 8'h03);
    check(ctl_o == 3'b011, "R7 R10 idle value", ctl_o, 3);
    wr(ta(1,7,2), 8'h02);
    go(2'd1);
    check(ctl_o == 3'b101, "R10 state 7 write dropped", ctl_o, 5);
    // R8 abort mid-run with start held high
    tick();
    start = 1'b1; abort = 1'b1;
    tick();
    start = 1'b0; abort = 1'b0;
    check(done_o && ctl_o == 3'b011 && !data_o, "R8 abort wins over start", ctl_o, 3);
    tick();
    check(ctl_o == 3'b011 && !done_o, "R8 stays idle", ctl_o, 3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule